// File: doc/BRIEF.md
# Center-Aligned PWM Bank with Edge-Selectable Dead Time

This block is a bank of PWM channels driven by one shared up/down reference counter. The counter climbs from zero to a programmed period and falls back to zero, over and over, and a clock prescaler sets how many clock cycles each counter step lasts. Every channel compares its duty value against this shared count. Each pulse is therefore symmetric about the counter's turning point at the top, and all channels in the bank stay center-aligned to one another.

Each channel can insert a programmable dead time on one edge of its pulse. With the trailing-edge option the falling edge is pushed later, so the pulse gets longer. With the leading-edge option the rising edge is pushed later, so the pulse gets shorter. Period, duty, dead time and edge selection are shadowed and take effect together as the counter leaves its minimum, so a pulse is never built from a mix of old and new settings. Polarity and a force-low control act on the output directly.

A typical use is to drive the gates of a half-bridge. One channel gives the reference timing. A second channel with the same duty and a dead time gives the same pulse with one edge offset from the reference.

Top module: `cpwm_dt_bank`

## Requirements
- R1: While rst_n is low, every bit of pwm_o is 0, cnt_o is 0 and cnt_up_o is 0.
- R2: The counter advances one step every clk_div_i+1 clock cycles. Starting from 0 it counts up to the latched period, then down to 0, and repeats, so one full cycle is 2×period steps. cnt_up_o is 1 during the rising half. cnt_o never exceeds the latched period, and the period must be at least 1.
- R3: With no dead time, a channel is active while its latched duty is nonzero and cnt_o+duty ≥ period. This gives an active width of 2×duty+1 steps centered on the counter peak. Channels with equal duty produce identical waveforms, and a duty of 0 is never active. pwm_o is registered and follows the counter state by one clock.
- R4: Trailing mode (dt_lead_i bit = 0): during the falling half the channel stays active while cnt_o+duty+dead ≥ period. The pulse is therefore longer by dead steps. The extension ends at the counter minimum at the latest.
- R5: Leading mode (dt_lead_i bit = 1): the rising edge is delayed by dead steps, so the active width is 2×duty+1−dead. If dead ≥ 2×duty+1, no pulse appears in that cycle.
- R6: A dead time of 0 gives exactly the R3 waveform in either mode.
- R7: pol_high_i bit = 1 drives the active state as 1. A bit value of 0 inverts the output, so the active state drives 0. Polarity is not shadowed.
- R8: force_low_i bit = 1 drives that pwm_o bit to 0 from the next clock, whatever the polarity. Force is not shadowed.
- R9: Period, duty, dead time and dead-time edge are latched only on the counter step that leaves 0. A change made in mid-cycle does not affect the cycle already in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| period_i | input | CNT_W | Counter peak value (≥1), shadowed |
| clk_div_i | input | PRE_W | Clock cycles per counter step, minus one |
| duty_i | input | NUM_CH×CNT_W | Per-channel duty, shadowed |
| dtime_i | input | NUM_CH×CNT_W | Per-channel dead time in steps, shadowed |
| dt_lead_i | input | NUM_CH | Per-channel dead-time edge: 0 trailing, 1 leading; shadowed |
| pol_high_i | input | NUM_CH | Per-channel polarity: 1 active high, 0 active low |
| force_low_i | input | NUM_CH | Per-channel force of the output to 0 |
| pwm_o | output | NUM_CH | Channel outputs |
| cnt_o | output | CNT_W | Shared reference counter value |
| cnt_up_o | output | 1 | 1 while the counter is rising |

## Verification
The assertions assume that period_i is never 0 when it is latched. They also assume that every input changes away from the rising clock edge. Under those conditions the counter stays within the latched period, moves by at most one step and only on a prescaler step, and sits at 0 only while in its falling state. The stimulus keeps every period at 6 or more. It drives each input on the falling clock edge. It makes its mid-cycle changes to period and duty on purpose, to show that they wait for the next counter minimum.

// File: rtl/cpwm_pkg.sv
package cpwm_pkg;
   typedef enum logic {
      DT_TRAIL = 1'b0,
      DT_LEAD  = 1'b1
   } dt_edge_e;
endpackage

// File: rtl/cpwm_timebase.sv
module cpwm_timebase #(
   parameter int CNT_W = 16,
   parameter int PRE_W = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [CNT_W-1:0] period_i,
   input  logic [PRE_W-1:0] clk_div_i,
   output logic [CNT_W-1:0] cnt_o,
   output logic             up_o,
   output logic [CNT_W-1:0] per_o,
   output logic             tick_o,
   output logic             load_o
);
   logic [PRE_W-1:0] pre_q;
   logic [CNT_W-1:0] cnt_q;
   logic [CNT_W-1:0] per_q;
   logic             up_q;

   assign tick_o = (pre_q >= clk_div_i);
   assign load_o = tick_o && !up_q && (cnt_q == '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pre_q <= '0;
      end else if (tick_o) begin
         pre_q <= '0;
      end else begin
         pre_q <= pre_q + PRE_W'(1);
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
         up_q  <= 1'b0;
         per_q <= '0;
      end else if (tick_o) begin
         if (up_q) begin
            if (cnt_q >= per_q) begin
               up_q  <= 1'b0;
               cnt_q <= cnt_q - CNT_W'(1);
            end else begin
               cnt_q <= cnt_q + CNT_W'(1);
            end
         end else if (cnt_q == '0) begin
            up_q  <= 1'b1;
            cnt_q <= CNT_W'(1);
            per_q <= period_i;
         end else begin
            cnt_q <= cnt_q - CNT_W'(1);
         end
      end
   end

   assign cnt_o = cnt_q;
   assign up_o  = up_q;
   assign per_o = per_q;
endmodule

// File: rtl/cpwm_slice.sv
module cpwm_slice
   import cpwm_pkg::*;
#(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load_i,
   input  logic [CNT_W-1:0] cnt_i,
   input  logic             up_i,
   input  logic [CNT_W-1:0] per_i,
   input  logic [CNT_W-1:0] duty_i,
   input  logic [CNT_W-1:0] dtime_i,
   input  logic             lead_i,
   input  logic             pol_high_i,
   input  logic             force_low_i,
   output logic             pwm_o
);
   localparam int EW = CNT_W + 2;

   logic [CNT_W-1:0] duty_q;
   logic [CNT_W-1:0] dt_q;
   dt_edge_e         mode_q;
   logic [EW-1:0]    c, d, t, p;
   logic             act;
   logic             out_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         duty_q <= '0;
         dt_q   <= '0;
         mode_q <= DT_TRAIL;
      end else if (load_i) begin
         duty_q <= duty_i;
         dt_q   <= dtime_i;
         mode_q <= dt_edge_e'(lead_i);
      end
   end

   assign c = EW'(cnt_i);
   assign d = EW'(duty_q);
   assign t = EW'(dt_q);
   assign p = EW'(per_i);

   // Active window is symmetric about the counter peak; dead time moves one edge.
   always_comb begin
      if (d == '0) begin
         act = 1'b0;
      end else if (mode_q == DT_LEAD) begin
         act = up_i ? (c + d >= p + t)
                    : ((c + d >= p) && (c + t <= p + d));
      end else begin
         act = up_i ? (c + d >= p) : (c + d + t >= p);
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_q <= 1'b0;
      end else if (force_low_i) begin
         out_q <= 1'b0;
      end else begin
         out_q <= pol_high_i ? act : ~act;
      end
   end

   assign pwm_o = out_q;
endmodule

// File: rtl/cpwm_dt_bank.sv
module cpwm_dt_bank #(
   parameter int NUM_CH = 3,
   parameter int CNT_W  = 16,
   parameter int PRE_W  = 4
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic [CNT_W-1:0]             period_i,
   input  logic [PRE_W-1:0]             clk_div_i,
   input  logic [NUM_CH-1:0][CNT_W-1:0] duty_i,
   input  logic [NUM_CH-1:0][CNT_W-1:0] dtime_i,
   input  logic [NUM_CH-1:0]            dt_lead_i,
   input  logic [NUM_CH-1:0]            pol_high_i,
   input  logic [NUM_CH-1:0]            force_low_i,
   output logic [NUM_CH-1:0]            pwm_o,
   output logic [CNT_W-1:0]             cnt_o,
   output logic                         cnt_up_o
);
   if (NUM_CH < 1) begin : g_bad_ch
      $error("cpwm_dt_bank: NUM_CH must be at least 1");
   end
   if (CNT_W < 4) begin : g_bad_cnt
      $error("cpwm_dt_bank: CNT_W must be at least 4");
   end
   if (PRE_W < 1) begin : g_bad_pre
      $error("cpwm_dt_bank: PRE_W must be at least 1");
   end

   logic [CNT_W-1:0] per_q;
   logic             tick;
   logic             load;

   cpwm_timebase #(.CNT_W(CNT_W), .PRE_W(PRE_W)) u_tb (
      .clk       (clk),
      .rst_n     (rst_n),
      .period_i  (period_i),
      .clk_div_i (clk_div_i),
      .cnt_o     (cnt_o),
      .up_o      (cnt_up_o),
      .per_o     (per_q),
      .tick_o    (tick),
      .load_o    (load)
   );

   for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
      cpwm_slice #(.CNT_W(CNT_W)) u_slice (
         .clk         (clk),
         .rst_n       (rst_n),
         .load_i      (load),
         .cnt_i       (cnt_o),
         .up_i        (cnt_up_o),
         .per_i       (per_q),
         .duty_i      (duty_i[g]),
         .dtime_i     (dtime_i[g]),
         .lead_i      (dt_lead_i[g]),
         .pol_high_i  (pol_high_i[g]),
         .force_low_i (force_low_i[g]),
         .pwm_o       (pwm_o[g])
      );
   end
endmodule

// File: rtl/cpwm_dt_bank_chk.sv
module cpwm_dt_bank_chk #(
   parameter int NUM_CH = 3,
   parameter int CNT_W  = 16
) (
   input logic              clk,
   input logic              rst_n,
   input logic [CNT_W-1:0]  cnt,
   input logic              up,
   input logic [CNT_W-1:0]  per_q,
   input logic              tick,
   input logic              load,
   input logic [NUM_CH-1:0] force_low,
   input logic [NUM_CH-1:0] pwm
);
   // R2: counter never passes the latched peak
   p_cnt_in_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
      cnt <= per_q);

   // R2: counter moves by at most one step
   p_single_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt != $past(cnt)) |-> ((cnt == $past(cnt) + CNT_W'(1)) ||
                               (cnt == $past(cnt) - CNT_W'(1))));

   // R2: counter holds between prescaler steps
   p_hold_without_tick_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !tick |=> $stable(cnt) && $stable(up));

   // R2: the minimum is only reached on the falling half
   p_min_is_falling_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt == '0) |-> !up);

   // R9: latched period changes only on a load step
   p_period_shadowed_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !load |=> $stable(per_q));

   for (genvar g = 0; g < NUM_CH; g++) begin : g_force
      // R8: forced channel is low on the next clock
      p_force_low_r8: assert property (@(posedge clk) disable iff (!rst_n)
         force_low[g] |=> !pwm[g]);
   end
endmodule

bind cpwm_dt_bank cpwm_dt_bank_chk #(.NUM_CH(NUM_CH), .CNT_W(CNT_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .cnt       (cnt_o),
   .up        (cnt_up_o),
   .per_q     (per_q),
   .tick      (tick),
   .load      (load),
   .force_low (force_low_i),
   .pwm       (pwm_o)
);

// File: tb/tb_cpwm_dt_bank.sv
module tb_cpwm_dt_bank;
   localparam int NCH = 3;
   localparam int CW  = 16;
   localparam int PW  = 4;

   logic                    clk = 1'b0;
   logic                    rst_n = 1'b0;
   logic [CW-1:0]           period = 16'd10;
   logic [PW-1:0]           clk_div = 4'd1;
   logic [NCH-1:0][CW-1:0]  duty = '0;
   logic [NCH-1:0][CW-1:0]  dtime = '0;
   logic [NCH-1:0]          dt_lead = '0;
   logic [NCH-1:0]          pol_high = '1;
   logic [NCH-1:0]          force_low = '0;
   logic [NCH-1:0]          pwm_o;
   logic [CW-1:0]           cnt_o;
   logic                    cnt_up_o;

   always #10 clk = ~clk;

   cpwm_dt_bank #(.NUM_CH(NCH), .CNT_W(CW), .PRE_W(PW)) dut (
      .clk(clk), .rst_n(rst_n), .period_i(period), .clk_div_i(clk_div),
      .duty_i(duty), .dtime_i(dtime), .dt_lead_i(dt_lead),
      .pol_high_i(pol_high), .force_low_i(force_low),
      .pwm_o(pwm_o), .cnt_o(cnt_o), .cnt_up_o(cnt_up_o)
   );

   int checks = 0;
   int fails  = 0;
   int cyc    = 0;
   bit cmp_en = 0;
   string ch_tag [NCH] = '{"R3", "R4", "R5"};

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d t=%0t", req, act, exp, $time);
      end
   endtask

   // Behavioural reference: counter state, shadows and expected outputs
   int m_pre = 0, m_cnt = 0, m_up = 0, m_per = 0;
   int m_duty [NCH] = '{0, 0, 0};
   int m_dt   [NCH] = '{0, 0, 0};
   bit m_lead [NCH] = '{0, 0, 0};
   logic [NCH-1:0] exp_pwm = '0;
   int exp_cnt = 0, exp_up = 0;

   function automatic bit active_f(int c, int up, int p, int d, int t, bit lead);
      if (d == 0) return 1'b0;
      if (lead) return up ? (c + d >= p + t) : ((c + d >= p) && (c + t <= p + d));
      return up ? (c + d >= p) : (c + d + t >= p);
   endfunction

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_pre = 0; m_cnt = 0; m_up = 0; m_per = 0;
         for (int i = 0; i < NCH; i++) begin m_duty[i] = 0; m_dt[i] = 0; m_lead[i] = 0; end
         exp_pwm = '0; exp_cnt = 0; exp_up = 0;
      end else begin
         bit tk;
         for (int i = 0; i < NCH; i++) begin
            bit a;
            a = active_f(m_cnt, m_up, m_per, m_duty[i], m_dt[i], m_lead[i]);
            exp_pwm[i] = force_low[i] ? 1'b0 : (pol_high[i] ? a : !a);
         end
         tk = (m_pre >= int'(clk_div));
         m_pre = tk ? 0 : m_pre + 1;
         if (tk) begin
            if (m_up != 0) begin
               if (m_cnt >= m_per) begin m_up = 0; m_cnt--; end
               else m_cnt++;
            end else if (m_cnt == 0) begin
               m_up = 1; m_cnt = 1; m_per = int'(period);
               for (int i = 0; i < NCH; i++) begin
                  m_duty[i] = int'(duty[i]); m_dt[i] = int'(dtime[i]); m_lead[i] = dt_lead[i];
               end
            end else m_cnt--;
         end
         exp_cnt = m_cnt; exp_up = m_up;
      end
   end

   always @(negedge clk) begin
      if (cmp_en) begin
         chk(int'(cnt_o) == exp_cnt, "R2 counter", int'(cnt_o), exp_cnt);
         chk(int'(cnt_up_o) == exp_up, "R2 direction", int'(cnt_up_o), exp_up);
         for (int i = 0; i < NCH; i++)
            chk(pwm_o[i] == exp_pwm[i], ch_tag[i], int'(pwm_o[i]), int'(exp_pwm[i]));
      end
   end

   task automatic summary();
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
   endtask

   always @(posedge clk) begin
      cyc++;
      if (cyc > 150000) begin
         fails++;
         $display("FAIL watchdog all-requirements actual=%0d expected<=150000", cyc);
         summary();
         $finish;
      end
   end

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   task automatic measure(input int n, output int c0, output int c1, output int c2, output int diff01);
      c0 = 0; c1 = 0; c2 = 0; diff01 = 0;
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         c0 += int'(pwm_o[0]); c1 += int'(pwm_o[1]); c2 += int'(pwm_o[2]);
         if (pwm_o[0] != pwm_o[1]) diff01++;
      end
   endtask

   task automatic cycle_len(output int n);
      while (cnt_o == 1 && cnt_up_o) @(negedge clk);
      while (!(cnt_o == 1 && cnt_up_o)) @(negedge clk);
      n = 0;
      while (cnt_o == 1 && cnt_up_o) begin @(negedge clk); n++; end
      while (!(cnt_o == 1 && cnt_up_o)) begin @(negedge clk); n++; end
   endtask

   initial begin
      int a0, a1, a2, df, mx, n;
      // R1: reset state
      idle(2);
      chk(pwm_o == '0, "R1 pwm", int'(pwm_o), 0);
      chk(cnt_o == '0, "R1 cnt", int'(cnt_o), 0);
      chk(cnt_up_o == 1'b0, "R1 dir", int'(cnt_up_o), 0);

      // Phase A: plain, trailing, leading (P=10, div=1 -> 40 clocks per cycle)
      duty[0] = 3; dtime[0] = 0; dt_lead[0] = 0;
      duty[1] = 3; dtime[1] = 2; dt_lead[1] = 0;
      duty[2] = 3; dtime[2] = 2; dt_lead[2] = 1;
      cmp_en = 1;
      rst_n = 1'b1;
      idle(100);
      measure(40, a0, a1, a2, df);
      chk(a0 == 14, "R3 width", a0, 14);
      chk(a1 == 18, "R4 width", a1, 18);
      chk(a2 == 10, "R5 width", a2, 10);

      // Phase B: zero dead time equals plain; oversized leading dead time
      ch_tag = '{"R3", "R6", "R5"};
      dtime[1] = 0; dt_lead[1] = 1;
      dtime[2] = 7;
      idle(80);
      measure(40, a0, a1, a2, df);
      chk(df == 0, "R6 equal-duty coincidence", df, 0);
      chk(a1 == 14, "R6 width", a1, 14);
      chk(a2 == 0, "R5 suppressed", a2, 0);

      // Phase C: polarity, force, zero duty
      ch_tag = '{"R7", "R8", "R3"};
      pol_high[0] = 0;
      force_low[1] = 1;
      duty[2] = 0; dtime[2] = 5; dt_lead[2] = 0;
      idle(80);
      measure(40, a0, a1, a2, df);
      chk(a0 == 26, "R7 inverted width", a0, 26);
      chk(a1 == 0, "R8 forced", a1, 0);
      chk(a2 == 0, "R3 zero duty", a2, 0);
      ch_tag = '{"R8", "R8", "R3"};
      while (!pwm_o[0]) @(negedge clk);
      force_low[0] = 1;
      @(negedge clk);
      chk(pwm_o[0] == 1'b0, "R8 immediate", int'(pwm_o[0]), 0);
      force_low = '0; pol_high = '1;
      duty[1] = 4; duty[2] = 5;

      // Phase D: mid-cycle period change waits for the minimum
      ch_tag = '{"R9", "R9", "R9"};
      idle(80);
      while (!(cnt_o == 2 && cnt_up_o)) @(negedge clk);
      period = 6; duty[0] = 2;
      mx = 0;
      do begin @(negedge clk); if (int'(cnt_o) > mx) mx = int'(cnt_o); end while (cnt_o != 0);
      chk(mx == 10, "R9 old period kept", mx, 10);
      while (cnt_o == 0) @(negedge clk);
      mx = 0;
      do begin if (int'(cnt_o) > mx) mx = int'(cnt_o); @(negedge clk); end while (cnt_o != 0);
      chk(mx == 6, "R2 new period", mx, 6);

      // Phase E: prescaler
      ch_tag = '{"R2", "R2", "R2"};
      clk_div = 0;
      idle(30);
      cycle_len(n);
      chk(n == 12, "R2 cycle div0", n, 12);
      clk_div = 3;
      idle(60);
      cycle_len(n);
      chk(n == 48, "R2 cycle div3", n, 48);
      idle(50);

      cmp_en = 0;
      summary();
      $finish;
   end
endmodule